// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block keeps the interrupt state of one processor core across 256 vectors. It holds three bitmaps: vectors waiting for service, vectors in service, and the trigger mode (level or edge) each pending vector arrived with. From the task priority and the highest vector in service it derives a processor priority. It raises `irq_present` whenever the highest waiting vector's 16-vector class is strictly above that priority. Vector numbers below 16 are reserved and never become pending.

The core takes an interrupt by holding `ack_req`. The block answers with a one-cycle `ack_grant` that carries the vector, and in doing so moves the vector from waiting to in service. An end-of-interrupt write retires the highest vector in service. It also emits a broadcast pulse carrying that vector and its trigger mode, so level-sensitive sources can re-arm. A control bit can suppress that broadcast.

A small sequencer orders the bitmap updates. `SEQ_IDLE` goes to `SEQ_EOI` when an end-of-interrupt write is new or held, and otherwise goes to `SEQ_ACK_SET` when `ack_req` meets `irq_present`. `SEQ_ACK_SET` always goes to `SEQ_ACK_CLR`, and both `SEQ_ACK_CLR` and `SEQ_EOI` return to `SEQ_IDLE`. Requests and register writes other than end-of-interrupt are taken in every state.

Top module: `vpt_tracker`

## Requirements
- R1: After reset all three bitmaps are empty, `tpr_q` and `ppr_q` are 0, and `irq_present`, `ack_grant`, `eoi_valid`, `req_taken` and `req_dup` are 0.
- R2: A request accepted for a vector that is not pending sets its pending bit and pulses `req_taken` one cycle later. A request for an already pending vector pulses `req_dup` instead and leaves the pending set unchanged.
- R3: A request is dropped, with neither pulse and no pending bit, when `hw_en` is low, when the software enable (control bit 8) is clear, or when the vector is below 16.
- R4: `ppr_q` equals `tpr_q` when `tpr_q[7:4]` is greater than or equal to the class of the highest in-service vector (0 when none is in service). Otherwise it equals that vector with its low four bits cleared.
- R5: `irq_present` is high only while the sequencer is idle, both enables are set, and the highest pending vector with its low four bits cleared is strictly greater than `ppr_q`. `irq_vector` always shows the highest pending vector, or 0 when none is pending.
- R6: Among pending vectors in any mix of 32-bit words, the numerically highest one is presented, granted and (among in-service vectors) retired.
- R7: With `ack_req` held while `irq_present` is high, `ack_grant` pulses for one cycle two cycles later with `ack_vector` set to the presented vector. Afterwards that vector is in service and no longer pending.
- R8: Register select 3 (end of interrupt) clears the highest in-service bit and its trigger bit. Two cycles after the write it pulses `eoi_valid` with `eoi_vector` and `eoi_level` (1 for level, 0 for edge).
- R9: While control bit 12 (directed end of interrupt) is set, the retirement still happens but `eoi_valid` stays low.
- R10: An end-of-interrupt write with nothing in service changes nothing and gives no broadcast.
- R11: Register select 0 loads `tpr_q` from `reg_wdata[7:0]`. Register select 1 loads `tpr_q` with `reg_wdata[3:0]` in bits 7:4 and zeros in bits 3:0.
- R12: Every enabled request at or above 16, including a duplicate, writes the vector's trigger bit from `req_level`, so the latest request decides the level reported at retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Hardware enable for request acceptance and presentation |
| req_valid | input | 1 | Fixed-mode request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| req_taken | output | 1 | Request became newly pending (one-cycle pulse) |
| req_dup | output | 1 | Request hit an already pending vector (one-cycle pulse) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 task priority, 1 four-bit priority alias, 2 control, 3 end of interrupt |
| reg_wdata | input | 32 | Write data; control uses bit 8 enable and bit 12 directed end of interrupt |
| tpr_q | output | 8 | Task priority |
| ppr_q | output | 8 | Processor priority |
| irq_present | output | 1 | A pending vector outranks the processor priority |
| irq_vector | output | 8 | Highest pending vector |
| ack_req | input | 1 | Core requests an interrupt; held until grant |
| ack_grant | output | 1 | Acknowledge completes (one-cycle pulse) |
| ack_vector | output | 8 | Granted vector |
| eoi_valid | output | 1 | End-of-interrupt broadcast pulse |
| eoi_vector | output | 8 | Retired vector |
| eoi_level | output | 1 | Retired vector was level-triggered |

## Verification
The hardest situation to reach is a nested set of in-service vectors that retire in the right order while lower pending vectors stay masked by the rising processor priority. The stimulus table reaches it by interleaving task-priority changes, acknowledges and end-of-interrupt writes, and checks the presented vector and priority after every step. A second hard case is a duplicate request that flips the trigger mode of an already pending vector. Directed sequences send a level request and then an edge request for the same vector, and the reverse. Each sequence is carried through acknowledge and retirement, so the changed mode shows up only on the broadcast level.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ACK_SET,
        SEQ_ACK_CLR,
        SEQ_EOI
    } seq_state_e;

    localparam logic [1:0] SEL_TPR  = 2'd0;
    localparam logic [1:0] SEL_CLS  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_EOI  = 2'd3;

    localparam int CTRL_EN_BIT   = 8;
    localparam int CTRL_DEOI_BIT = 12;

endpackage

// File: rtl/vpt_find_hi.sv
module vpt_find_hi #(
    parameter int NVEC   = 256,
    parameter int WORD_W = 32,
    localparam int VEC_W  = $clog2(NVEC),
    localparam int NWORDS = NVEC / WORD_W,
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int WRD_W  = VEC_W - BIT_W
) (
    input  logic [NVEC-1:0]  bits,
    output logic             found,
    output logic [VEC_W-1:0] index
);

    logic [NWORDS-1:0] word_any;
    logic [BIT_W-1:0]  word_pos [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [BIT_W-1:0] pos;
        always_comb begin
            pos = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits[w*WORD_W + b]) pos = BIT_W'(b);
            end
        end
        assign word_any[w] = |bits[w*WORD_W +: WORD_W];
        assign word_pos[w] = pos;
    end

    // higher words are visited last, so the topmost non-empty word wins
    always_comb begin
        found = 1'b0;
        index = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (word_any[w]) begin
                found = 1'b1;
                index = {WRD_W'(w), word_pos[w]};
            end
        end
    end

endmodule

// File: rtl/vpt_prio.sv
module vpt_prio #(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4,
    localparam int LOW_W = VEC_W - CLS_W
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_found,
    input  logic [CLS_W-1:0] isr_cls,
    input  logic             irr_found,
    input  logic [CLS_W-1:0] irr_cls,
    input  logic             enabled,
    input  logic             idle,
    output logic [VEC_W-1:0] ppr,
    output logic             present
);

    logic [CLS_W-1:0] svc_cls;
    logic [VEC_W-1:0] pend_floor;

    assign svc_cls    = isr_found ? isr_cls : '0;
    assign pend_floor = {irr_cls, {LOW_W{1'b0}}};

    always_comb begin
        if (tpr[VEC_W-1 -: CLS_W] >= svc_cls) ppr = tpr;
        else                                   ppr = {svc_cls, {LOW_W{1'b0}}};
    end

    assign present = enabled && idle && irr_found && (pend_floor > ppr);

endmodule

// File: rtl/vpt_seq.sv
module vpt_seq
    import vpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ack_req,
    input  logic       irq_present,
    input  logic       eoi_wr,
    output logic       cap_ack,
    output logic       set_isr,
    output logic       clr_irr,
    output logic       do_eoi,
    output logic       ack_grant,
    output seq_state_e state_o
);

    seq_state_e state, nxt;
    logic       eoi_hold;
    logic       eoi_due;

    assign eoi_due = eoi_wr || eoi_hold;

    // state register, plus the held end-of-interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            eoi_hold <= 1'b0;
        end else begin
            state <= nxt;
            if (state == SEQ_IDLE) eoi_hold <= 1'b0;
            else if (eoi_wr)       eoi_hold <= 1'b1;
        end
    end

    // next state and strobes
    always_comb begin
        nxt       = state;
        cap_ack   = 1'b0;
        set_isr   = 1'b0;
        clr_irr   = 1'b0;
        do_eoi    = 1'b0;
        ack_grant = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (eoi_due) begin
                    nxt = SEQ_EOI;
                end else if (ack_req && irq_present) begin
                    nxt     = SEQ_ACK_SET;
                    cap_ack = 1'b1;
                end
            end
            SEQ_ACK_SET: begin
                set_isr = 1'b1;
                nxt     = SEQ_ACK_CLR;
            end
            SEQ_ACK_CLR: begin
                clr_irr   = 1'b1;
                ack_grant = 1'b1;
                nxt       = SEQ_IDLE;
            end
            SEQ_EOI: begin
                do_eoi = 1'b1;
                nxt    = SEQ_IDLE;
            end
        endcase
    end

    assign state_o = state;

endmodule

// File: rtl/vpt_tracker.sv
module vpt_tracker
    import vpt_pkg::*;
#(
    parameter int NVEC    = 256,
    parameter int WORD_W  = 32,
    parameter int CLS_W   = 4,
    parameter int MIN_VEC = 16,
    parameter int DATA_W  = 32,
    localparam int VEC_W  = $clog2(NVEC),
    localparam int LOW_W  = VEC_W - CLS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic              req_level,
    output logic              req_taken,
    output logic              req_dup,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [VEC_W-1:0]  tpr_q,
    output logic [VEC_W-1:0]  ppr_q,
    output logic              irq_present,
    output logic [VEC_W-1:0]  irq_vector,
    input  logic              ack_req,
    output logic              ack_grant,
    output logic [VEC_W-1:0]  ack_vector,
    output logic              eoi_valid,
    output logic [VEC_W-1:0]  eoi_vector,
    output logic              eoi_level
);

    logic [NVEC-1:0]  irr_q, isr_q, tmr_q;
    logic [VEC_W-1:0] tpr;
    logic             sw_en, deoi_q;
    logic [VEC_W-1:0] cur_vec;

    logic             irr_found, isr_found;
    logic [VEC_W-1:0] irr_hi, isr_hi;
    logic             present;
    logic [VEC_W-1:0] ppr;

    logic             cap_ack, set_isr, clr_irr, do_eoi, grant;
    seq_state_e       seq_state;
    logic             req_ok, eoi_wr, clr_same;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata;

    assign eoi_wr   = reg_wr && (reg_sel == SEL_EOI);
    assign req_ok   = req_valid && hw_en && sw_en &&
                      (req_vector >= VEC_W'(MIN_VEC));
    assign clr_same = clr_irr && (cur_vec == req_vector);

    vpt_find_hi #(.NVEC(NVEC), .WORD_W(WORD_W)) u_irr_find (
        .bits  (irr_q),
        .found (irr_found),
        .index (irr_hi)
    );

    vpt_find_hi #(.NVEC(NVEC), .WORD_W(WORD_W)) u_isr_find (
        .bits  (isr_q),
        .found (isr_found),
        .index (isr_hi)
    );

    vpt_prio #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_prio (
        .tpr       (tpr),
        .isr_found (isr_found),
        .isr_cls   (isr_hi[VEC_W-1 -: CLS_W]),
        .irr_found (irr_found),
        .irr_cls   (irr_hi[VEC_W-1 -: CLS_W]),
        .enabled   (hw_en && sw_en),
        .idle      (seq_state == SEQ_IDLE),
        .ppr       (ppr),
        .present   (present)
    );

    vpt_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_req     (ack_req),
        .irq_present (present),
        .eoi_wr      (eoi_wr),
        .cap_ack     (cap_ack),
        .set_isr     (set_isr),
        .clr_irr     (clr_irr),
        .do_eoi      (do_eoi),
        .ack_grant   (grant),
        .state_o     (seq_state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q      <= '0;
            isr_q      <= '0;
            tmr_q      <= '0;
            tpr        <= '0;
            sw_en      <= 1'b0;
            deoi_q     <= 1'b0;
            cur_vec    <= '0;
            req_taken  <= 1'b0;
            req_dup    <= 1'b0;
            eoi_valid  <= 1'b0;
            eoi_vector <= '0;
            eoi_level  <= 1'b0;
        end else begin
            req_taken <= 1'b0;
            req_dup   <= 1'b0;
            eoi_valid <= 1'b0;

            if (reg_wr) begin
                case (reg_sel)
                    SEL_TPR:  tpr <= reg_wdata[VEC_W-1:0];
                    SEL_CLS:  tpr <= {reg_wdata[CLS_W-1:0], {LOW_W{1'b0}}};
                    SEL_CTRL: begin
                        sw_en  <= reg_wdata[CTRL_EN_BIT];
                        deoi_q <= reg_wdata[CTRL_DEOI_BIT];
                    end
                    default: ;
                endcase
            end

            if (cap_ack) cur_vec <= irr_hi;
            if (set_isr) isr_q[cur_vec] <= 1'b1;
            if (clr_irr) irr_q[cur_vec] <= 1'b0;

            if (do_eoi && isr_found) begin
                isr_q[isr_hi] <= 1'b0;
                tmr_q[isr_hi] <= 1'b0;
                eoi_valid     <= !deoi_q;
                eoi_vector    <= isr_hi;
                eoi_level     <= tmr_q[isr_hi];
            end

            // a new request is written last so it wins over any clear
            if (req_ok) begin
                tmr_q[req_vector] <= req_level;
                irr_q[req_vector] <= 1'b1;
                req_taken <= !irr_q[req_vector] || clr_same;
                req_dup   <= irr_q[req_vector] && !clr_same;
            end
        end
    end

    assign tpr_q       = tpr;
    assign ppr_q       = ppr;
    assign irq_present = present;
    assign irq_vector  = irr_found ? irr_hi : '0;
    assign ack_grant   = grant;
    assign ack_vector  = cur_vec;

endmodule

// File: rtl/vpt_checker.sv
module vpt_checker #(
    parameter int VEC_W   = 8,
    parameter int CLS_W   = 4,
    parameter int MIN_VEC = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hw_en,
    input logic [VEC_W-1:0] req_vector,
    input logic             req_taken,
    input logic             req_dup,
    input logic [VEC_W-1:0] tpr_q,
    input logic [VEC_W-1:0] ppr_q,
    input logic             irq_present,
    input logic [VEC_W-1:0] irq_vector,
    input logic             ack_grant,
    input logic [VEC_W-1:0] ack_vector,
    input logic             eoi_valid,
    input logic             deoi_q
);

    p_taken_dup_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_taken && req_dup));

    p_low_vec_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_taken || req_dup) |-> ($past(req_vector) >= VEC_W'(MIN_VEC)));

    p_hw_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_en |=> (!req_taken && !req_dup));

    p_ppr_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ppr_q >= tpr_q);

    p_present_above_ppr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_present |-> ({irq_vector[VEC_W-1 -: CLS_W], {(VEC_W-CLS_W){1'b0}}} > ppr_q));

    p_grant_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_grant |=> !ack_grant);

    p_grant_vec_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_grant |-> (ack_vector >= VEC_W'(MIN_VEC)));

    p_eoi_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |=> !eoi_valid);

    p_directed_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> !$past(deoi_q));

endmodule

bind vpt_tracker vpt_checker #(.VEC_W(VEC_W), .CLS_W(CLS_W), .MIN_VEC(MIN_VEC)) u_vpt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_en       (hw_en),
    .req_vector  (req_vector),
    .req_taken   (req_taken),
    .req_dup     (req_dup),
    .tpr_q       (tpr_q),
    .ppr_q       (ppr_q),
    .irq_present (irq_present),
    .irq_vector  (irq_vector),
    .ack_grant   (ack_grant),
    .ack_vector  (ack_vector),
    .eoi_valid   (eoi_valid),
    .deoi_q      (deoi_q)
);

// File: tb/vpt_tracker_test.sv
`timescale 1ns/1ps
module vpt_tracker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_en = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic        req_level = 1'b0;
    logic        req_taken, req_dup;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  tpr_q, ppr_q, irq_vector, ack_vector, eoi_vector;
    logic        irq_present, ack_grant, eoi_valid, eoi_level;
    logic        ack_req = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vpt_tracker uut (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en),
        .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
        .req_taken(req_taken), .req_dup(req_dup),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .tpr_q(tpr_q), .ppr_q(ppr_q),
        .irq_present(irq_present), .irq_vector(irq_vector),
        .ack_req(ack_req), .ack_grant(ack_grant), .ack_vector(ack_vector),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level)
    );

    localparam int EN   = 32'h0000_0100;
    localparam int DEOI = 32'h0000_1000;

    // {op, arg, lvl, present, vector, ppr, aux vector, aux level}
    // op 0 request, 1 task priority write, 2 acknowledge, 3 end of interrupt
    localparam int NROW = 15;
    localparam logic [36:0] TBL [NROW] = '{
        {2'd0, 8'h45, 1'b0, 1'b1, 8'h45, 8'h00, 8'h00, 1'b0},
        {2'd0, 8'h92, 1'b1, 1'b1, 8'h92, 8'h00, 8'h00, 1'b0},
        {2'd1, 8'h95, 1'b0, 1'b0, 8'h92, 8'h95, 8'h00, 1'b0},
        {2'd1, 8'h80, 1'b0, 1'b1, 8'h92, 8'h80, 8'h00, 1'b0},
        {2'd2, 8'h00, 1'b0, 1'b0, 8'h45, 8'h90, 8'h92, 1'b0},
        {2'd0, 8'hA0, 1'b0, 1'b1, 8'hA0, 8'h90, 8'h00, 1'b0},
        {2'd2, 8'h00, 1'b0, 1'b0, 8'h45, 8'hA0, 8'hA0, 1'b0},
        {2'd3, 8'h00, 1'b0, 1'b0, 8'h45, 8'h90, 8'hA0, 1'b0},
        {2'd3, 8'h00, 1'b0, 1'b0, 8'h45, 8'h80, 8'h92, 1'b1},
        {2'd1, 8'h00, 1'b0, 1'b1, 8'h45, 8'h00, 8'h00, 1'b0},
        {2'd2, 8'h00, 1'b0, 1'b0, 8'h00, 8'h40, 8'h45, 1'b0},
        {2'd0, 8'h10, 1'b0, 1'b0, 8'h10, 8'h40, 8'h00, 1'b0},
        {2'd3, 8'h00, 1'b0, 1'b1, 8'h10, 8'h00, 8'h45, 1'b0},
        {2'd2, 8'h00, 1'b0, 1'b0, 8'h00, 8'h10, 8'h10, 1'b0},
        {2'd3, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic req(input logic [7:0] v, input logic l);
        req_valid = 1'b1; req_vector = v; req_level = l;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ack(output logic [7:0] gv, output logic got);
        got = 1'b0; gv = '0;
        ack_req = 1'b1;
        for (int i = 0; i < 8 && !got; i++) begin
            @(negedge clk);
            if (ack_grant) begin got = 1'b1; gv = ack_vector; end
        end
        ack_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic eoi(output logic [7:0] v, output logic l, output logic vld);
        wr(2'd3, 32'h0);
        @(negedge clk);
        vld = eoi_valid; v = eoi_vector; l = eoi_level;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [7:0] gv, ev;
        logic got, el, evld;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_present", irq_present, 0);
        chk("R1 ppr", ppr_q, 0);
        chk("R1 tpr", tpr_q, 0);
        chk("R1 ack_grant", ack_grant, 0);
        chk("R1 eoi_valid", eoi_valid, 0);
        chk("R1 req_taken", req_taken, 0);
        chk("R1 irq_vector", irq_vector, 0);

        // R3 drops: software enable clear, hardware enable low, low vector
        req(8'h50, 1'b0);
        chk("R3 sw off taken", req_taken, 0);
        chk("R3 sw off dup", req_dup, 0);
        wr(2'd2, EN);
        hw_en = 1'b0;
        req(8'h60, 1'b0);
        chk("R3 hw off taken", req_taken, 0);
        hw_en = 1'b1;
        req(8'h0F, 1'b0);
        chk("R3 low vector taken", req_taken, 0);
        chk("R3 nothing pending", irq_present, 0);
        chk("R3 nothing pending vector", irq_vector, 0);

        // R4 R5 R7 R8 table walk
        for (int i = 0; i < NROW; i++) begin
            logic [36:0] row;
            row = TBL[i];
            case (row[36:35])
                2'd0: begin
                    req(row[34:27], row[26]);
                    chk("R2 table taken", req_taken, 1);
                end
                2'd1: wr(2'd0, {24'h0, row[34:27]});
                2'd2: begin
                    ack(gv, got);
                    chk("R7 table grant seen", got, 1);
                    chk("R7 table grant vector", gv, row[8:1]);
                end
                default: begin
                    eoi(ev, el, evld);
                    chk("R8 table eoi valid", evld, 1);
                    chk("R8 table eoi vector", ev, row[8:1]);
                    chk("R8 table eoi level", el, row[0]);
                end
            endcase
            chk("R5 table present", irq_present, row[25]);
            chk("R5 table vector", irq_vector, row[24:17]);
            chk("R4 table ppr", ppr_q, row[16:9]);
        end

        // R2 duplicate, R12 duplicate edge overrides level
        req(8'h50, 1'b1);
        chk("R2 first taken", req_taken, 1);
        req(8'h50, 1'b0);
        chk("R2 dup flagged", req_dup, 1);
        chk("R2 dup not taken", req_taken, 0);
        chk("R2 vector pending", irq_vector, 8'h50);

        // R5 enable gating
        wr(2'd2, 32'h0);
        chk("R5 gated by sw enable", irq_present, 0);
        wr(2'd2, EN);
        chk("R5 ungated", irq_present, 1);

        ack(gv, got);
        chk("R7 grant vector", gv, 8'h50);
        chk("R7 no longer pending", irq_vector, 0);
        eoi(ev, el, evld);
        chk("R12 edge after level", el, 0);
        chk("R8 broadcast", evld, 1);

        req(8'h60, 1'b0);
        req(8'h60, 1'b1);
        ack(gv, got);
        eoi(ev, el, evld);
        chk("R12 level after edge", el, 1);
        chk("R8 vector 60", ev, 8'h60);

        // R9 directed end of interrupt mutes broadcast
        wr(2'd2, EN | DEOI);
        req(8'h70, 1'b1);
        ack(gv, got);
        chk("R9 in service ppr", ppr_q, 8'h70);
        eoi(ev, el, evld);
        chk("R9 broadcast muted", evld, 0);
        chk("R9 retired ppr", ppr_q, 0);

        // R10 nothing in service
        wr(2'd2, EN);
        wr(2'd0, 32'h33);
        eoi(ev, el, evld);
        chk("R10 no broadcast", evld, 0);
        chk("R10 ppr unchanged", ppr_q, 8'h33);

        // R11 task priority writes
        wr(2'd0, 32'hABCD_12C4);
        chk("R11 low byte kept", tpr_q, 8'hC4);
        wr(2'd1, 32'h0000_00F7);
        chk("R11 alias nibble", tpr_q, 8'h70);

        // R6 highest across words
        wr(2'd0, 32'h0);
        req(8'h21, 1'b0);
        req(8'hFF, 1'b1);
        req(8'h3F, 1'b0);
        chk("R6 top vector", irq_vector, 8'hFF);
        ack(gv, got);
        chk("R6 grant FF", gv, 8'hFF);
        chk("R6 ppr F0", ppr_q, 8'hF0);
        chk("R6 masked", irq_present, 0);
        chk("R6 next pending", irq_vector, 8'h3F);
        eoi(ev, el, evld);
        chk("R6 retire FF", ev, 8'hFF);
        ack(gv, got);
        chk("R6 grant 3F", gv, 8'h3F);
        ack(gv, got);
        chk("R5 class 2 below ppr 30", got, 0);
        eoi(ev, el, evld);
        chk("R6 retire 3F", ev, 8'h3F);
        ack(gv, got);
        chk("R6 grant 21", gv, 8'h21);
        eoi(ev, el, evld);
        chk("R6 retire 21", ev, 8'h21);
        chk("R4 all retired", ppr_q, 0);

        finish_run();
    end

endmodule